// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each access of a four-word burst. A start address is captured when a burst begins. The low two bits then step through one of two fixed orders, while the remaining bits stay at the captured value. The sequencer sits between a memory port's strobe decoder and its array. The decoder says when to capture and when to step, and this block says which word is next.

Two orders are offered, chosen by a static select input. In the interleaved order, each low address is the start value XOR the beat index. In the linear order, the low address is the start value plus the beat index, wrapping inside the aligned four-word block. The beat index is kept in its own counter and is never derived from the previous address. After the fourth beat, a further step returns to the start word.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high `rst` sets `addr_out` to 0 and `beat_idx` to 0 at the next rising edge. This holds even in the middle of a burst.
- R2: When `load` is 1 at a rising edge, `addr_out` equals `load_addr` and `beat_idx` equals 0 after that edge, in either order mode.
- R3: `advance_n` has no effect on the edge that samples `load` = 1. The first beat is always the captured start word.
- R4: With `interleave_mode` = 1, the low two bits of `addr_out` equal (start low bits) XOR `beat_idx`. For a start of 01, the sequence is 01, 00, 11, 10.
- R5: With `interleave_mode` = 0, the low two bits equal (start low bits + `beat_idx`) mod 4. For a start of 10, the sequence is 10, 11, 00, 01.
- R6: When `load` = 0 and `advance_n` = 1 at an edge, the burst is suspended: `beat_idx` and `addr_out` keep their values.
- R7: When `load` = 0 and `advance_n` = 0 at an edge, `beat_idx` increments mod 4. A step after beat 3 returns `beat_idx` to 0, so the address returns to the start word.
- R8: Bits above the low two of `addr_out` equal the bits of the last captured address and never change during stepping.
- R9: `interleave_mode` acts combinationally on the current beat. Changing it alters the low address bits without a clock edge and leaves `beat_idx` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture `load_addr` and start a burst |
| load_addr | input | ADDR_W | Start address of the burst |
| advance_n | input | 1 | Active-low step request; high suspends |
| interleave_mode | input | 1 | 1 = XOR order (default strap), 0 = linear wrap order |
| addr_out | output | ADDR_W | Address of the current beat |
| beat_idx | output | BURST_BITS | Index of the current beat, 0 to 3 |

## Verification
The stepping function is driven with starts of 01, 10, 11 and 00, in both orders. A start of 01 or 11 tells XOR apart from addition, because the two orders diverge at the second beat. A start of 10 in linear mode shows the wrap inside the aligned block, and a start of 00 cannot separate the orders, which is used to confirm that the beat index is the same in both. Suspend cycles placed between steps show that a held step does not change the beat. A step after beat 3 shows the return to the start word. A reload in the middle of a burst, with the step input asserted, shows that a new start wins over the step. The mode is also flipped between clock edges to show that the same beat is remapped without the counter moving.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   // Order applied to the low address bits during a burst.
   typedef enum logic {
      ORDER_LINEAR     = 1'b0,
      ORDER_INTERLEAVE = 1'b1
   } burst_order_e;

   // Interleaved order: the beat index toggles bits of the start word.
   function automatic logic [1:0] xor_step(input logic [1:0] start, input logic [1:0] beat);
      return start ^ beat;
   endfunction

   // Linear order: the beat index is added, carry out of the block is lost.
   function automatic logic [1:0] add_step(input logic [1:0] start, input logic [1:0] beat);
      return start + beat;
   endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   output logic [ADDR_W-1:0] base_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
      end else if (load) begin
         base_q <= load_addr;
      end
   end

   // R8: the captured start changes only on a load
   p_base_held_r8 : assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(base_q));

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int BURST_BITS = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  load,
   input  logic                  advance_n,
   output logic [BURST_BITS-1:0] beat_q
);

   localparam logic [BURST_BITS-1:0] ONE = BURST_BITS'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         beat_q <= '0;
      end else if (load) begin
         beat_q <= '0;
      end else if (!advance_n) begin
         beat_q <= beat_q + ONE;
      end
   end

   // R3: a load restarts the burst whatever the step request
   p_load_restarts_r3 : assert property (@(posedge clk) disable iff (rst)
      load |=> beat_q == '0);

   // R6: a suspended cycle keeps the beat
   p_suspend_holds_r6 : assert property (@(posedge clk) disable iff (rst)
      (!load && advance_n) |=> $stable(beat_q));

   // R7: each accepted step moves one beat with wrap
   p_step_wraps_r7 : assert property (@(posedge clk) disable iff (rst)
      (!load && !advance_n) |=> beat_q == BURST_BITS'($past(beat_q) + ONE));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_seq_pkg::*;
#(
   parameter int BURST_BITS = 2
) (
   input  logic [BURST_BITS-1:0] start_lo,
   input  logic [BURST_BITS-1:0] beat,
   input  burst_order_e          order,
   output logic [BURST_BITS-1:0] lo_out
);

   logic [BURST_BITS-1:0] xor_lo;
   logic [BURST_BITS-1:0] add_lo;

   generate
      if (BURST_BITS == 2) begin : g_pkg_fn
         assign xor_lo = xor_step(start_lo, beat);
         assign add_lo = add_step(start_lo, beat);
      end else begin : g_generic
         assign xor_lo = start_lo ^ beat;
         assign add_lo = start_lo + beat;
      end
   endgenerate

   assign lo_out = (order == ORDER_INTERLEAVE) ? xor_lo : add_lo;

   // R2: beat zero is the start word in both orders
   always_comb begin
      if (beat == '0) begin
         p_beat0_start_r2 : assert (lo_out == start_lo);
      end
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W     = 19,
   parameter int BURST_BITS = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  load,
   input  logic [ADDR_W-1:0]     load_addr,
   input  logic                  advance_n,
   input  logic                  interleave_mode,
   output logic [ADDR_W-1:0]     addr_out,
   output logic [BURST_BITS-1:0] beat_idx
);

   localparam int HI_W = ADDR_W - BURST_BITS;

   generate
      if (BURST_BITS < 1) begin : g_bad_burst
         $error("BURST_BITS must be at least 1");
      end
      if (HI_W < 1) begin : g_bad_width
         $error("ADDR_W must exceed BURST_BITS");
      end
   endgenerate

   logic [ADDR_W-1:0]     base_q;
   logic [BURST_BITS-1:0] beat_q;
   logic [BURST_BITS-1:0] lo_sel;
   burst_order_e          order;

   assign order = interleave_mode ? ORDER_INTERLEAVE : ORDER_LINEAR;

   burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .load_addr (load_addr),
      .base_q    (base_q)
   );

   burst_beat_ctr #(.BURST_BITS(BURST_BITS)) u_ctr (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .advance_n (advance_n),
      .beat_q    (beat_q)
   );

   burst_order_map #(.BURST_BITS(BURST_BITS)) u_map (
      .start_lo (base_q[BURST_BITS-1:0]),
      .beat     (beat_q),
      .order    (order),
      .lo_out   (lo_sel)
   );

   assign addr_out = {base_q[ADDR_W-1:BURST_BITS], lo_sel};
   assign beat_idx = beat_q;

   // R2: the full start address appears right after a load
   p_load_visible_r2 : assert property (@(posedge clk) disable iff (rst)
      load |=> addr_out == $past(load_addr));

   // R8: upper bits ride through stepping untouched
   p_upper_stable_r8 : assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(addr_out[ADDR_W-1:BURST_BITS]));

   // R1: reset returns the burst to word zero
   p_reset_clears_r1 : assert property (@(posedge clk)
      rst |=> (addr_out == '0 && beat_idx == '0));

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 19;

   typedef struct packed {
      logic          ld;
      logic [AW-1:0] a;
      logic          adv_n;
      logic          md;
      logic [1:0]    exp_lo;
      logic [1:0]    exp_bt;
   } vec_t;

   localparam int NVEC = 18;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 19'h12341, 1'b0, 1'b1, 2'b01, 2'd0}, // R2 R3 load, step ignored
      '{1'b0, 19'h00000, 1'b0, 1'b1, 2'b00, 2'd1}, // R4
      '{1'b0, 19'h00000, 1'b0, 1'b1, 2'b11, 2'd2}, // R4
      '{1'b0, 19'h00000, 1'b1, 1'b1, 2'b11, 2'd2}, // R6 suspend
      '{1'b0, 19'h00000, 1'b0, 1'b1, 2'b10, 2'd3}, // R4
      '{1'b0, 19'h00000, 1'b0, 1'b1, 2'b01, 2'd0}, // R7 wrap to start
      '{1'b1, 19'h7FFFE, 1'b0, 1'b0, 2'b10, 2'd0}, // R2 R3 linear start
      '{1'b0, 19'h00000, 1'b0, 1'b0, 2'b11, 2'd1}, // R5
      '{1'b0, 19'h00000, 1'b0, 1'b0, 2'b00, 2'd2}, // R5 R8 no carry out
      '{1'b0, 19'h00000, 1'b0, 1'b0, 2'b01, 2'd3}, // R5
      '{1'b0, 19'h00000, 1'b0, 1'b0, 2'b10, 2'd0}, // R7
      '{1'b1, 19'h00003, 1'b1, 1'b1, 2'b11, 2'd0}, // R2
      '{1'b0, 19'h00000, 1'b0, 1'b1, 2'b10, 2'd1}, // R4
      '{1'b0, 19'h00000, 1'b0, 1'b1, 2'b01, 2'd2}, // R4
      '{1'b0, 19'h00000, 1'b0, 1'b0, 2'b10, 2'd3}, // R5 linear 3+3
      '{1'b1, 19'h2AAA4, 1'b0, 1'b0, 2'b00, 2'd0}, // R3 reload mid-burst
      '{1'b0, 19'h00000, 1'b0, 1'b0, 2'b01, 2'd1}, // R5
      '{1'b0, 19'h00000, 1'b1, 1'b1, 2'b01, 2'd1}  // R6 R4
   };

   logic          clk = 1'b0;
   logic          rst;
   logic          load;
   logic [AW-1:0] load_addr;
   logic          advance_n;
   logic          interleave_mode;
   logic [AW-1:0] addr_out;
   logic [1:0]    beat_idx;

   int checks = 0;
   int fails  = 0;
   logic done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_seq dut_i (
      .clk             (clk),
      .rst             (rst),
      .load            (load),
      .load_addr       (load_addr),
      .advance_n       (advance_n),
      .interleave_mode (interleave_mode),
      .addr_out        (addr_out),
      .beat_idx        (beat_idx)
   );

   task automatic check(input string req, input logic [AW-1:0] exp_a, input logic [1:0] exp_b);
      checks++;
      if (addr_out !== exp_a || beat_idx !== exp_b) begin
         fails++;
         $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                  req, addr_out, beat_idx, exp_a, exp_b);
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog (R1..): actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] upper;
      rst = 1'b1; load = 1'b0; load_addr = '0; advance_n = 1'b1; interleave_mode = 1'b1;
      upper = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1 reset", '0, 2'd0);
      rst = 1'b0;

      for (int i = 0; i < NVEC; i++) begin
         load = VECS[i].ld;
         load_addr = VECS[i].a;
         advance_n = VECS[i].adv_n;
         interleave_mode = VECS[i].md;
         if (VECS[i].ld) upper = {VECS[i].a[AW-1:2], 2'b00};
         @(posedge clk);
         #1;
         check($sformatf("R2-table vec %0d", i), {upper[AW-1:2], VECS[i].exp_lo}, VECS[i].exp_bt);
         @(negedge clk);
      end

      // R9: mode flips remap the current beat without a clock edge
      load = 1'b1; load_addr = 19'h40001; advance_n = 1'b1; interleave_mode = 1'b1;
      @(posedge clk); #1;
      @(negedge clk);
      load = 1'b0; advance_n = 1'b0;
      @(posedge clk); #1;
      check("R4 beat1 start01", 19'h40000, 2'd1);
      @(negedge clk);
      advance_n = 1'b1;
      interleave_mode = 1'b0;
      #1;
      check("R9 linear remap", 19'h40002, 2'd1);
      interleave_mode = 1'b1;
      #1;
      check("R9 back to xor", 19'h40000, 2'd1);

      // R6: several suspended cycles in a row
      repeat (3) @(posedge clk);
      #1;
      check("R6 long suspend", 19'h40000, 2'd1);

      // R1: reset in the middle of a burst
      @(negedge clk);
      rst = 1'b1; advance_n = 1'b0;
      @(posedge clk); #1;
      check("R1 mid-burst reset", '0, 2'd0);
      @(negedge clk);
      rst = 1'b0; advance_n = 1'b1;

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule